// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block watches the addresses a processor core issues for instruction fetch and for data access, and compares each against a small bank of programmable breakpoint entries. Instruction and data addresses have separate banks. Every entry holds a base address, a don't-care mask and enable bits. A set mask bit removes that address bit from the compare, so a single entry can cover an aligned range of addresses.

On a qualified match the block raises a registered debug exception for that side one cycle after the strobe. The exception carries the index of the matching entry. If several entries match, the lowest index wins. The exception stays raised until the core acknowledges it. While it is pending, further compares on that side are ignored, so one access produces exactly one exception.

Entries are loaded through a simple write port that selects a side, an entry index and a field.

Top module: `bp_match_unit`

## Requirements
- R1: The instruction bank and the data bank are independent. A configuration write with `cfg_dside`=0 changes only instruction entries, and a write with `cfg_dside`=1 changes only data entries.
- R2: An entry matches an address when `(addr & ~mask) == (entry_addr & ~mask)` over all 32 bits. Mask bit 1 means "don't care".
- R3: A qualified instruction match with `if_valid`=1 at a clock edge sets `iexc`=1 at that edge, with `iexc_idx` giving the matching entry. The output is visible in the following cycle, before the fetched operation can complete.
- R4: A data entry matches a read only when its read-enable bit is set, and a write only when its write-enable bit is set. `da_write`=1 marks a write. A qualified data match sets `dexc`/`dexc_idx` at the edge of the access.
- R5: When several enabled entries of one bank match, the reported index is the lowest one.
- R6: After synchronous reset every entry is cleared and disabled, and `iexc` and `dexc` are 0.
- R7: Once raised, an exception and its index hold until the acknowledge input of that side (`iexc_ack` or `dexc_ack`) is sampled high, which clears it at that edge. While the exception is pending, all compares on that side are ignored.
- R8: When the strobe of a side (`if_valid`, `da_valid`) is 0, that side raises no exception whatever the address.
- R9: Field encoding for `cfg_field`: 0 writes the entry address, 1 writes the mask, and 2 writes the control word. In the control word, bit 0 is the instruction enable (instruction side) or the read enable (data side), and bit 1 is the write enable (data side only). Code 3 writes nothing. A write takes effect for compares from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dside | input | 1 | 0 = instruction bank, 1 = data bank |
| cfg_idx | input | 1 | Entry index |
| cfg_field | input | 2 | Field select (see R9) |
| cfg_wdata | input | 32 | Write data |
| if_valid | input | 1 | Instruction issue strobe |
| if_addr | input | 32 | Instruction address |
| da_valid | input | 1 | Data access strobe |
| da_addr | input | 32 | Data address |
| da_write | input | 1 | 1 = write access, 0 = read |
| iexc_ack | input | 1 | Instruction exception acknowledge |
| dexc_ack | input | 1 | Data exception acknowledge |
| iexc | output | 1 | Instruction breakpoint exception |
| iexc_idx | output | 1 | Index of matching instruction entry |
| dexc | output | 1 | Data breakpoint exception |
| dexc_idx | output | 1 | Index of matching data entry |

## Verification
The assertions assume that acknowledge is only meaningful while an exception is pending, and that strobes and addresses are stable across each clock edge. The stimulus drives all inputs on the falling edge, and it includes stray acknowledges and configuration writes coinciding with matches. The stimulus also lets acknowledge and a fresh match land on the same edge, which the design must resolve as a clear. In the random phase addresses are drawn from a narrow window, so masked hits, multi-entry overlaps and disabled entries occur often.

// File: rtl/bp_pkg.sv
package bp_pkg;
    parameter int ADDR_W = 32;
    parameter int NUM_BP = 2;
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_NONE = 2'd3
    } bp_field_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] dcare;
        logic              en_main;   // exec enable or read enable
        logic              en_wr;     // write enable (data bank)
    } bp_entry_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } bp_hit_t;

    function automatic logic addr_hits(input logic [ADDR_W-1:0] a,
                                       input bp_entry_t e);
        return ((a ^ e.base) & ~e.dcare) == '0;
    endfunction
endpackage

// File: rtl/bp_regfile.sv
module bp_regfile
    import bp_pkg::*;
#(
    parameter int N = NUM_BP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [1:0]            field,
    input  logic [ADDR_W-1:0]     wdata,
    output bp_entry_t [N-1:0]     entries
);
    bp_field_e fsel;
    assign fsel = bp_field_e'(field);

    always_ff @(posedge clk) begin
        if (rst) begin
            entries <= '0;
        end else if (we) begin
            case (fsel)
                FLD_ADDR: entries[idx].base  <= wdata;
                FLD_MASK: entries[idx].dcare <= wdata;
                FLD_CTRL: begin
                    entries[idx].en_main <= wdata[0];
                    entries[idx].en_wr   <= wdata[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bp_cmp_bank.sv
module bp_cmp_bank
    import bp_pkg::*;
#(
    parameter int N = NUM_BP
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      qual,
    input  bp_entry_t [N-1:0] entries,
    output bp_hit_t           result
);
    logic [N-1:0] raw;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign raw[g] = valid && qual[g] && addr_hits(addr, entries[g]);
    end

    always_comb begin
        result = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw[i]) begin
                result.hit = 1'b1;
                result.idx = IDX_W'(i);
            end
        end
    end

    // R8: no hit without a strobe
    always_comb begin
        if (result.hit) p_hit_needs_strobe_r8 : assert (valid);
    end
endmodule

// File: rtl/bp_exc_latch.sv
module bp_exc_latch
    import bp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  bp_hit_t          hit_in,
    output logic             exc,
    output logic [IDX_W-1:0] exc_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            exc     <= 1'b0;
            exc_idx <= '0;
        end else if (exc) begin
            if (ack) exc <= 1'b0;
        end else if (hit_in.hit) begin
            exc     <= 1'b1;
            exc_idx <= hit_in.idx;
        end
    end

    p_hold_r7 : assert property (@(posedge clk) disable iff (rst)
        exc && !ack |=> exc && $stable(exc_idx));
    p_ack_clear_r7 : assert property (@(posedge clk) disable iff (rst)
        exc && ack |=> !exc);
    p_reset_idle_r6 : assert property (@(posedge clk)
        $past(rst) |-> !exc);
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
    import bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_dside,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              if_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic              da_write,
    input  logic              iexc_ack,
    input  logic              dexc_ack,
    output logic              iexc,
    output logic [IDX_W-1:0]  iexc_idx,
    output logic              dexc,
    output logic [IDX_W-1:0]  dexc_idx
);
    bp_entry_t [NUM_BP-1:0] i_ent, d_ent;
    logic [NUM_BP-1:0]      i_qual, d_qual;
    bp_hit_t                i_hit, d_hit;

    bp_regfile #(.N(NUM_BP)) u_iregs (
        .clk(clk), .rst(rst), .we(cfg_we && !cfg_dside), .idx(cfg_idx),
        .field(cfg_field), .wdata(cfg_wdata), .entries(i_ent));
    bp_regfile #(.N(NUM_BP)) u_dregs (
        .clk(clk), .rst(rst), .we(cfg_we && cfg_dside), .idx(cfg_idx),
        .field(cfg_field), .wdata(cfg_wdata), .entries(d_ent));

    for (genvar g = 0; g < NUM_BP; g++) begin : g_qual
        assign i_qual[g] = i_ent[g].en_main;
        assign d_qual[g] = da_write ? d_ent[g].en_wr : d_ent[g].en_main;
    end

    bp_cmp_bank #(.N(NUM_BP)) u_icmp (
        .valid(if_valid), .addr(if_addr), .qual(i_qual),
        .entries(i_ent), .result(i_hit));
    bp_cmp_bank #(.N(NUM_BP)) u_dcmp (
        .valid(da_valid), .addr(da_addr), .qual(d_qual),
        .entries(d_ent), .result(d_hit));

    bp_exc_latch u_ilat (
        .clk(clk), .rst(rst), .ack(iexc_ack), .hit_in(i_hit),
        .exc(iexc), .exc_idx(iexc_idx));
    bp_exc_latch u_dlat (
        .clk(clk), .rst(rst), .ack(dexc_ack), .hit_in(d_hit),
        .exc(dexc), .exc_idx(dexc_idx));

    p_irise_strobe_r8 : assert property (@(posedge clk) disable iff (rst)
        $rose(iexc) |-> $past(if_valid));
    p_drise_strobe_r8 : assert property (@(posedge clk) disable iff (rst)
        $rose(dexc) |-> $past(da_valid));
    p_ipend_ignores_r7 : assert property (@(posedge clk) disable iff (rst)
        iexc && !iexc_ack && if_valid |=> $stable(iexc_idx));
endmodule

// File: tb/sim_bp_match_unit.sv
module sim_bp_match_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0, cfg_dside = 0;
    logic [0:0]  cfg_idx = 0;
    logic [1:0]  cfg_field = 0;
    logic [31:0] cfg_wdata = 0;
    logic        if_valid = 0, da_valid = 0, da_write = 0;
    logic [31:0] if_addr = 0, da_addr = 0;
    logic        iexc_ack = 0, dexc_ack = 0;
    logic        iexc, dexc;
    logic [0:0]  iexc_idx, dexc_idx;

    always #4 clk = ~clk;

    bp_match_unit u0 (.*);

    // reference model state: [side][entry]
    logic [31:0] m_base [2][2];
    logic [31:0] m_mask [2][2];
    logic [1:0]  m_ctl  [2][2];
    logic        m_exc  [2];
    integer      m_idx  [2];
    integer checks = 0, errors = 0, cycles = 0;
    string  tag = "R6";

    function automatic integer find(input int side, input logic [31:0] a,
                                    input logic wr);
        for (int e = 0; e < 2; e++) begin
            logic en;
            en = (side == 1 && wr) ? m_ctl[side][e][1] : m_ctl[side][e][0];
            if (en && ((a & ~m_mask[side][e]) == (m_base[side][e] & ~m_mask[side][e])))
                return e;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                m_exc[s] = 0; m_idx[s] = 0;
                for (int e = 0; e < 2; e++) begin
                    m_base[s][e] = 0; m_mask[s][e] = 0; m_ctl[s][e] = 0;
                end
            end
        end else begin
            integer h;
            if (m_exc[0]) begin
                if (iexc_ack) m_exc[0] = 0;
            end else if (if_valid) begin
                h = find(0, if_addr, 1'b0);
                if (h >= 0) begin m_exc[0] = 1; m_idx[0] = h; end
            end
            if (m_exc[1]) begin
                if (dexc_ack) m_exc[1] = 0;
            end else if (da_valid) begin
                h = find(1, da_addr, da_write);
                if (h >= 0) begin m_exc[1] = 1; m_idx[1] = h; end
            end
            if (cfg_we) begin
                case (cfg_field)
                    2'd0: m_base[cfg_dside][cfg_idx] = cfg_wdata;
                    2'd1: m_mask[cfg_dside][cfg_idx] = cfg_wdata;
                    2'd2: m_ctl[cfg_dside][cfg_idx]  = cfg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always @(posedge clk) begin
        #2;
        checks++;
        if (iexc !== m_exc[0] || (m_exc[0] && iexc_idx !== 1'(m_idx[0]))) begin
            errors++;
            $display("FAIL %s iexc/idx act %b/%0d exp %b/%0d", tag, iexc, iexc_idx,
                     m_exc[0], m_idx[0]);
        end
        checks++;
        if (dexc !== m_exc[1] || (m_exc[1] && dexc_idx !== 1'(m_idx[1]))) begin
            errors++;
            $display("FAIL %s dexc/idx act %b/%0d exp %b/%0d", tag, dexc, dexc_idx,
                     m_exc[1], m_idx[1]);
        end
    end

    always @(posedge clk) begin
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog act running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic side, input logic idx, input logic [1:0] f,
                       input logic [31:0] d);
        cfg_we = 1; cfg_dside = side; cfg_idx = idx; cfg_field = f; cfg_wdata = d;
        cyc();
        cfg_we = 0;
    endtask

    task automatic fetch(input logic [31:0] a);
        if_valid = 1; if_addr = a; cyc(); if_valid = 0;
    endtask

    task automatic access(input logic [31:0] a, input logic wr);
        da_valid = 1; da_addr = a; da_write = wr; cyc(); da_valid = 0;
    endtask

    task automatic iack(); iexc_ack = 1; cyc(); iexc_ack = 0; endtask
    task automatic dack(); dexc_ack = 1; cyc(); dexc_ack = 0; endtask

    initial begin
        cyc(3);
        rst = 0;
        tag = "R6"; fetch(32'h0); access(32'h0, 0); access(32'h0, 1); cyc(2);
        tag = "R9";
        cfg(0, 0, 2'd0, 32'h0000_1000);
        cfg(0, 0, 2'd1, 32'h0000_000F);
        cfg(0, 0, 2'd3, 32'hFFFF_FFFF);
        cfg(0, 0, 2'd2, 32'h1);
        tag = "R3"; fetch(32'h0000_100C); cyc();
        tag = "R7"; fetch(32'h0000_1000); cyc(3); iack(); cyc();
        tag = "R2"; fetch(32'h0000_1010); fetch(32'h8000_1005); fetch(32'h0000_1003); iack();
        tag = "R5";
        cfg(0, 1, 2'd0, 32'h0000_1000);
        cfg(0, 1, 2'd1, 32'h0000_00FF);
        cfg(0, 1, 2'd2, 32'h1);
        fetch(32'h0000_1004); iack(); fetch(32'h0000_1080); iack();
        tag = "R8"; if_addr = 32'h0000_1000; cyc(3);
        tag = "R1";
        cfg(1, 0, 2'd0, 32'h0000_1000);
        cfg(1, 0, 2'd2, 32'h0);
        fetch(32'h0000_1001); access(32'h0000_1001, 0); iack();
        tag = "R4";
        cfg(1, 0, 2'd0, 32'h0000_2000);
        cfg(1, 0, 2'd1, 32'h0000_0003);
        cfg(1, 0, 2'd2, 32'h2);
        access(32'h0000_2001, 0); access(32'h0000_2002, 1); cyc(); dack();
        cfg(1, 0, 2'd2, 32'h1);
        access(32'h0000_2003, 1); access(32'h0000_2000, 0); dack();
        tag = "R7"; access(32'h0000_2000, 0);
        da_valid = 1; da_addr = 32'h0000_2000; da_write = 0; dexc_ack = 1; cyc();
        dexc_ack = 0; da_valid = 0; cyc();
        tag = "R2";
        for (int k = 0; k < 400; k++) begin
            cfg_we    = ($urandom % 6) == 0;
            cfg_dside = $urandom; cfg_idx = $urandom; cfg_field = $urandom;
            cfg_wdata = $urandom % 64;
            if_valid  = $urandom; if_addr = $urandom % 64;
            da_valid  = $urandom; da_addr = $urandom % 64; da_write = $urandom;
            iexc_ack  = ($urandom % 4) == 0;
            dexc_ack  = ($urandom % 4) == 0;
            cyc();
        end
        cfg_we = 0; if_valid = 0; da_valid = 0;
        tag = "R6"; rst = 1; cyc(2); rst = 0; cyc(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule